// File: doc/BRIEF.md
# DRAM Geometry Probe Aliasing Memory

This block stands in for a DRAM array while boot firmware works out how the part is organised. Firmware picks a trial geometry (row, bank and column address widths) and writes it to a 32-bit configuration word. It then writes and reads patterns in the RAM window and watches for wrap-around. The block is built for one fixed chip, selected by the `SIZE_MIB` parameter. It compares the trial geometry with the real one. When the two agree, the block steps aside. When they differ, it folds every RAM access onto a small array of cells. Addresses that would wrap on a real part then land on the same storage.

Folding works on each field separately. The address offset is cut into column, bank and row fields using the trial widths. Each field is then reduced to the position of its highest set bit, and only positions below the chip's real width for that field are looked at. The three positions pick one cell out of a 16 × 3 × 13 array of 32-bit words.

Memory traffic uses a valid/ready request channel and a valid/ready response channel, with one response per accepted request. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle. A response is held stable until a cycle in which `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low, so one transaction at most is ever in flight. The configuration port is a plain one-cycle write strobe.

Top module: `dram_geom_probe_alias`

## Requirements
- R1: After reset, aliasing is off. Every well-sized access then gets a response with `rsp_hit`=0 (not handled, so a normal backing store would serve it) and `rsp_rdata`=0.
- R2: A configuration write with bit 0 clear sets the trial geometry. Row width = cfg[7:4]+1, bank width = cfg[2]+2, column width = cfg[11:8]+3.
- R3: The chip geometry depends on the size. 256 MiB has 12 row, 3 bank and 13 column bits. 512 MiB has 13/3/13. 1024 MiB has 14/3/13. Any other size stops elaboration. After an accepted configuration write, aliasing is on exactly when at least one trial width differs from the chip width. For the default 256 MiB chip, the matching word is 0x0000_0AB4.
- R4: A configuration write with bit 0 set (dual rank) leaves the trial geometry and the aliasing state unchanged.
- R5: The byte offset is split with the column field in the lowest bits, the bank field directly above it, and the row field above the bank field. Each field has its trial width.
- R6: Each field maps to the index of its highest set bit. Only positions below the chip width for that field are examined. A field with no such bit set maps to index 0.
- R7: While aliasing is on, a 4-byte read returns the last value written to its cell. All addresses that fold to the same cell share one storage word.
- R8: `req_bytes` must be 4. Any other value gives a response with `rsp_err`=1, `rsp_hit`=0 and `rsp_rdata`=0, and the cells are not changed.
- R9: A request is accepted when `req_valid` and `req_ready` are both high, and its response is valid one cycle later. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response is held unchanged.
- R10: Reset clears every cell to zero.
- R11: A write made while aliasing is off does not change any cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (trial geometry, dual-rank bit 0) |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset into the RAM window |
| req_bytes | input | 3 | Access size in bytes (only 4 is legal) |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed this cycle when high with rsp_valid |
| rsp_hit | output | 1 | Access was served by the alias cells |
| rsp_err | output | 1 | Access size was illegal |
| rsp_rdata | output | DW | Read data (zero for writes, misses and errors) |

## Verification
The bench goes after folding corners. Address bits above the chip's column width but inside a wide trial column must alias to column 0; a design that scanned the trial width instead would index past the array or pick a different cell. Two addresses whose fields share only their top bit must read back the same word; a lowest-bit or binary-index decode would separate them. A dual-rank write followed by accesses shows whether that write was wrongly applied, and a matching write after a mismatch shows whether aliasing really turns off. Back-pressure is tested with a second request held pending, which catches a response that changes while stalled, or a request that is lost or taken twice.

// File: rtl/geo_probe_pkg.sv
package geo_probe_pkg;

  // Widths of the three address fields, each wide enough for 1..18
  typedef struct packed {
    logic [4:0] row_w;
    logic [4:0] bank_w;
    logic [4:0] col_w;
  } geo_t;

  localparam int CFG_W        = 32;
  localparam int CFG_DUAL_BIT = 0;

  function automatic bit size_supported(input int mib);
    return (mib == 256) || (mib == 512) || (mib == 1024);
  endfunction

  function automatic geo_t chip_geo(input int mib);
    geo_t g;
    g.bank_w = 5'd3;
    g.col_w  = 5'd13;
    case (mib)
      512:     g.row_w = 5'd13;
      1024:    g.row_w = 5'd14;
      default: g.row_w = 5'd12;
    endcase
    return g;
  endfunction

  function automatic geo_t decode_cfg(input logic [CFG_W-1:0] w);
    geo_t g;
    g.row_w  = {1'b0, w[7:4]}  + 5'd1;
    g.bank_w = {4'b0, w[2]}    + 5'd2;
    g.col_w  = {1'b0, w[11:8]} + 5'd3;
    return g;
  endfunction

endpackage

// File: rtl/geo_cfg_reg.sv
module geo_cfg_reg
  import geo_probe_pkg::*;
#(
  parameter int TRUE_ROW_W  = 12,
  parameter int TRUE_BANK_W = 3,
  parameter int TRUE_COL_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output geo_t             trial,
  output logic             alias_on
);

  localparam geo_t CHIP = '{row_w:  5'(TRUE_ROW_W),
                            bank_w: 5'(TRUE_BANK_W),
                            col_w:  5'(TRUE_COL_W)};

  geo_t next_geo;
  logic take;

  always_comb begin
    next_geo = decode_cfg(cfg_wdata);
    take     = cfg_we && !cfg_wdata[CFG_DUAL_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial    <= CHIP;
      alias_on <= 1'b0;
    end else if (take) begin
      trial    <= next_geo;
      alias_on <= (next_geo.row_w  != CHIP.row_w)  ||
                  (next_geo.bank_w != CHIP.bank_w) ||
                  (next_geo.col_w  != CHIP.col_w);
    end
  end

endmodule

// File: rtl/geo_field_msb.sv
module geo_field_msb #(
  parameter int AW    = 30,
  parameter int LIMIT = 13,
  parameter int IW    = 4
) (
  input  logic [AW-1:0] field,
  output logic [IW-1:0] idx
);

  // Highest set bit among positions [LIMIT-1:0]; zero when none set
  always_comb begin
    idx = '0;
    for (int i = 0; i < LIMIT; i++) begin
      if (field[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/geo_addr_fold.sv
module geo_addr_fold
  import geo_probe_pkg::*;
#(
  parameter int AW          = 30,
  parameter int ROWS        = 16,
  parameter int BANKS       = 3,
  parameter int COLS        = 13,
  parameter int TRUE_ROW_W  = 12,
  parameter int TRUE_BANK_W = 3,
  parameter int TRUE_COL_W  = 13,
  localparam int NCELL      = ROWS * BANKS * COLS,
  localparam int CELL_AW    = $clog2(NCELL)
) (
  input  geo_t               trial,
  input  logic [AW-1:0]      addr,
  output logic [CELL_AW-1:0] cell_idx
);

  localparam int RIW = $clog2(ROWS);
  localparam int BIW = $clog2(BANKS);
  localparam int CIW = $clog2(COLS);
  localparam int NF  = 3;
  localparam int IWM = 8;

  logic [5:0]    bank_sh, row_sh;
  logic [AW-1:0] ones;
  logic [AW-1:0] fields [NF];
  logic [IWM-1:0] pos   [NF];

  always_comb begin
    ones      = '1;
    bank_sh   = {1'b0, trial.col_w};
    row_sh    = {1'b0, trial.col_w} + {1'b0, trial.bank_w};
    fields[0] = addr & ~(ones << trial.col_w);
    fields[1] = (addr >> bank_sh) & ~(ones << trial.bank_w);
    fields[2] = (addr >> row_sh)  & ~(ones << trial.row_w);
  end

  // Field 0 column, 1 bank, 2 row; each scanned only up to the chip width
  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam int LIM = (f == 0) ? TRUE_COL_W :
                         (f == 1) ? TRUE_BANK_W : TRUE_ROW_W;
    geo_field_msb #(.AW(AW), .LIMIT(LIM), .IW(IWM)) u_msb (
      .field (fields[f]),
      .idx   (pos[f])
    );
  end

  logic [RIW-1:0] r_i;
  logic [BIW-1:0] b_i;
  logic [CIW-1:0] c_i;

  always_comb begin
    c_i      = pos[0][CIW-1:0];
    b_i      = pos[1][BIW-1:0];
    r_i      = pos[2][RIW-1:0];
    cell_idx = CELL_AW'((int'(r_i) * BANKS + int'(b_i)) * COLS + int'(c_i));
  end

endmodule

// File: rtl/geo_cell_store.sv
module geo_cell_store #(
  parameter int DW    = 32,
  parameter int NCELL = 624,
  localparam int CELL_AW = $clog2(NCELL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CELL_AW-1:0] idx,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata
);

  logic [DW-1:0] cells [NCELL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wdata;
    end
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/dram_geom_probe_alias.sv
module dram_geom_probe_alias
  import geo_probe_pkg::*;
#(
  parameter int SIZE_MIB = 256,
  parameter int AW       = 30,
  parameter int DW       = 32,
  parameter int ROWS     = 16,
  parameter int BANKS    = 3,
  parameter int COLS     = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_bytes,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);

  localparam geo_t CHIP    = chip_geo(SIZE_MIB);
  localparam int   T_ROW   = int'(CHIP.row_w);
  localparam int   T_BANK  = int'(CHIP.bank_w);
  localparam int   T_COL   = int'(CHIP.col_w);
  localparam int   NCELL   = ROWS * BANKS * COLS;
  localparam int   CELL_AW = $clog2(NCELL);
  localparam logic [2:0] WORD_BYTES = 3'd4;

  if (!size_supported(SIZE_MIB)) begin : g_bad_size
    $error("dram_geom_probe_alias: unsupported SIZE_MIB");
  end
  if ((T_ROW > ROWS) || (T_BANK > BANKS) || (T_COL > COLS) || (AW < 22)) begin : g_bad_dims
    $error("dram_geom_probe_alias: cell array too small for chip geometry");
  end

  geo_t               trial;
  logic               alias_on;
  logic [CELL_AW-1:0] cell_idx;
  logic [DW-1:0]      cell_rdata;

  geo_cfg_reg #(
    .TRUE_ROW_W (T_ROW),
    .TRUE_BANK_W(T_BANK),
    .TRUE_COL_W (T_COL)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .trial    (trial),
    .alias_on (alias_on)
  );

  geo_addr_fold #(
    .AW         (AW),
    .ROWS       (ROWS),
    .BANKS      (BANKS),
    .COLS       (COLS),
    .TRUE_ROW_W (T_ROW),
    .TRUE_BANK_W(T_BANK),
    .TRUE_COL_W (T_COL)
  ) u_fold (
    .trial   (trial),
    .addr    (req_addr),
    .cell_idx(cell_idx)
  );

  logic accept, size_ok, hit_now, store_we;
  logic rsp_valid_q, rsp_hit_q, rsp_err_q;
  logic [DW-1:0] rsp_rdata_q;

  always_comb begin
    req_ready = !rsp_valid_q || rsp_ready;
    accept    = req_valid && req_ready;
    size_ok   = (req_bytes == WORD_BYTES);
    hit_now   = alias_on && size_ok;
    store_we  = accept && req_write && hit_now;
  end

  geo_cell_store #(
    .DW   (DW),
    .NCELL(NCELL)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (store_we),
    .idx  (cell_idx),
    .wdata(req_wdata),
    .rdata(cell_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= hit_now;
      rsp_err_q   <= !size_ok;
      rsp_rdata_q <= (hit_now && !req_write) ? cell_rdata : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/dram_geom_probe_alias_chk.sv
module dram_geom_probe_alias_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [31:0]   cfg_wdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_bytes,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_hit,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic          alias_on
);

  p_accept_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit) && $stable(rsp_err)));

  p_hit_follows_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bytes == 3'd4) |=> (rsp_hit == $past(alias_on)));

  p_bad_size_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bytes != 3'd4) |=> (rsp_err && !rsp_hit));

  p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rdata == '0));

  p_dual_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0]) |=> $stable(alias_on));

endmodule

bind dram_geom_probe_alias dram_geom_probe_alias_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_bytes(req_bytes),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_hit  (rsp_hit),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .alias_on (alias_on)
);

// File: tb/tb_dram_geom_probe_alias.sv
module tb_dram_geom_probe_alias;

  localparam int AW = 30;
  localparam int DW = 32;
  localparam int CHIP_ROW = 12, CHIP_BANK = 3, CHIP_COL = 13;
  localparam logic [31:0] CFG_MATCH = 32'h0000_0AB4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_bytes = 3'd4;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_hit, rsp_err;
  logic [DW-1:0] rsp_rdata;

  always #10 clk = ~clk;

  dram_geom_probe_alias dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // Reference model
  int m_rw = CHIP_ROW, m_bw = CHIP_BANK, m_cw = CHIP_COL;
  bit m_on = 1'b0;
  logic [31:0] mcell [16][3][13];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int top_bit(input longint v, input int lim);
    for (int p = lim - 1; p >= 0; p--) if (v[p]) return p;
    return 0;
  endfunction

  task automatic fold(input logic [AW-1:0] a, output int r, output int b, output int c);
    longint av = longint'(a);
    longint cv = av % (longint'(1) << m_cw);
    longint bv = (av >> m_cw) % (longint'(1) << m_bw);
    longint rv = (av >> (m_cw + m_bw)) % (longint'(1) << m_rw);
    c = top_bit(cv, CHIP_COL);
    b = top_bit(bv, CHIP_BANK);
    r = top_bit(rv, CHIP_ROW);
  endtask

  task automatic cfg_write(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!w[0]) begin
      m_rw = int'(w[7:4]) + 1;
      m_bw = int'(w[2]) + 2;
      m_cw = int'(w[11:8]) + 3;
      m_on = !(m_rw == CHIP_ROW && m_bw == CHIP_BANK && m_cw == CHIP_COL);
    end
  endtask

  // Issue one access with rsp_ready high; called and returns at a negedge
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [2:0] nb, input string tag);
    int r, b, c;
    bit ehit;
    logic [DW-1:0] erd;
    fold(a, r, b, c);
    ehit = m_on && (nb == 3'd4);
    erd  = (ehit && !wr) ? mcell[r][b][c] : '0;
    if (ehit && wr) mcell[r][b][c] = d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bytes = nb;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, {tag, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit === ehit, {tag, " hit"}, 64'(rsp_hit), 64'(ehit));
    chk(rsp_err === (nb != 3'd4), {tag, " R8 err"}, 64'(rsp_err), 64'(nb != 3'd4));
    chk(rsp_rdata === erd, {tag, " rdata"}, 64'(rsp_rdata), 64'(erd));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int r0, b0, c0;
    logic [DW-1:0] hold_a;
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r < 16; r++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 13; c++) mcell[r][b][c] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, aliasing off
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R1 req_ready after reset", 64'(req_ready), 1);
    access(1'b0, 30'h0000_1234, '0, 3'd4, "R1 read while off");
    // R11: write while off must not land in a cell
    access(1'b1, 30'h0000_1000, 32'hDEAD_BEEF, 3'd4, "R11 write while off");

    // R2/R3: mismatched row width 16 turns aliasing on
    cfg_write(32'h0000_0AF4);
    access(1'b0, 30'h0000_1000, '0, 3'd4, "R11/R10 read cleared cell");
    access(1'b0, 30'h3FFF_FFFC, '0, 3'd4, "R10 far cell cleared");

    // R7/R6: two addresses with same top column bit alias
    access(1'b1, 30'h0000_1000, 32'hA5A5_0001, 3'd4, "R7 write col12");
    access(1'b0, 30'h0000_1FFF, '0, 3'd4, "R7 R6 alias read col12");
    // R5/R6: bank field sits just above column; row above bank
    access(1'b1, 30'h0000_4000, 32'h0B0B_0002, 3'd4, "R5 write bank1");
    access(1'b0, 30'h0000_6000, '0, 3'd4, "R5 read bank1 alias");
    access(1'b1, 30'h0001_0000, 32'h0C0C_0003, 3'd4, "R5 write row0 bit");
    access(1'b0, 30'h0001_0000, '0, 3'd4, "R5 read row0");
    access(1'b0, 30'h0000_0000, '0, 3'd4, "R6 zero address");

    // R6: wide trial column; bits at/above chip width 13 are ignored
    cfg_write(32'h0000_0FB4);
    access(1'b1, 30'h0000_0000, 32'h1111_0004, 3'd4, "R6 write zero");
    access(1'b0, 30'h0000_8000, '0, 3'd4, "R6 col bit15 folds to 0");
    fold(30'h0000_8000, r0, b0, c0);
    chk(c0 == 0, "R6 model col index", 64'(c0), 0);

    // R8: illegal sizes
    access(1'b1, 30'h0000_0000, 32'hFFFF_FFFF, 3'd2, "R8 write size2");
    access(1'b0, 30'h0000_0000, '0, 3'd4, "R8 cell unchanged");
    access(1'b0, 30'h0000_0000, '0, 3'd1, "R8 read size1");

    // R4: dual-rank write is ignored
    cfg_write(32'h0000_0AB5);
    access(1'b0, 30'h0000_8000, '0, 3'd4, "R4 dual rank ignored");

    // R3: matching geometry disables aliasing
    cfg_write(CFG_MATCH);
    access(1'b0, 30'h0000_1000, '0, 3'd4, "R3 match disables");
    cfg_write(32'h0000_0AB0);
    access(1'b0, 30'h0000_1000, '0, 3'd4, "R3 bank mismatch enables");

    // R9: back-pressure with a second request waiting
    rsp_ready = 1'b0;
    access(1'b0, 30'h0000_1000, '0, 3'd4, "R9 first under stall");
    hold_a = rsp_rdata;
    chk(req_ready === 1'b0, "R9 ready low while stalled", 64'(req_ready), 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 30'h0000_0000; req_bytes = 3'd4;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_rdata === hold_a, "R9 response held",
        64'(rsp_rdata), 64'(hold_a));
    rsp_ready = 1'b1;
    fold(30'h0000_0000, r0, b0, c0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_rdata === mcell[r0][b0][c0], "R9 pending request served",
        64'(rsp_rdata), 64'(mcell[r0][b0][c0]));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 response drained", 64'(rsp_valid), 0);

    // Random mix against the model (R2 R3 R5 R6 R7 R8)
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 9));
      if (k == 0) begin
        logic [31:0] w = $urandom();
        if ($urandom_range(0, 3) == 0) w = CFG_MATCH;
        cfg_write(w);
      end else begin
        logic [AW-1:0] a;
        logic [2:0] nb;
        if ($urandom_range(0, 1) == 0) a = AW'($urandom());
        else a = (AW'(1) << $urandom_range(0, AW - 1)) | (AW'(1) << $urandom_range(0, AW - 1));
        nb = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7)) : 3'd4;
        access($urandom_range(0, 1) == 1, a, $urandom(), nb, "R7 random");
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule